// File: doc/BRIEF.md
# Linked-List Transmit Descriptor Fetcher

This block moves outgoing frames from memory to a MAC transmitter. Software builds a circular chain of transmit descriptors. Each descriptor is eight 32-bit words, and only the first four are used. Word 0 carries flags and status. Word 1 carries the byte count. Word 2 carries the buffer address. Word 3 carries the address of the following descriptor.

When `startEn` is raised, the engine begins at `listBase` and works through the chain.
- It reads a descriptor and checks whether the engine owns it.
- It sends the buffer as a byte stream with valid/ready flow control.
- It writes word 0 back with the ownership bit cleared, which returns the descriptor to software.
- It then moves to the next descriptor.

When the engine meets a descriptor that software still holds, it sets a sticky "buffer unavailable" status bit and waits. It fetches that same descriptor again only after a poll-demand pulse. A descriptor can also ask for a "frame done" status bit when it completes. Each status bit can be masked into a single interrupt line.

Memory is reached through a single-word request/acknowledge port. A request is held, with a stable address and direction, until it is acknowledged. Read data arrives together with the acknowledge.

Top module: `txdma_top`

## Requirements
- R1: When `startEn` goes high while the engine is idle, the engine fetches the descriptor at `listBase`. It reads its words 0, 1, 2 and 3 at byte offsets +0, +4, +8 and +12, in that order. A memory request keeps its address and direction stable until `memAck`.
- R2: A descriptor that is owned (word 0 bit 31 = 1), has both first-segment (bit 28) and last-segment (bit 29) set, and has a non-zero count (word 1 bits 12:0) sends exactly that many bytes.
  - Bytes are taken from word 2 with its two low address bits ignored.
  - Within each 32-bit word, bytes are sent least significant first.
  - `txLast` is high on the final byte only.
- R3: While `txValid` is high and `txReady` is low, `txValid`, `txData` and `txLast` hold their values.
- R4: After a descriptor is processed, the engine writes word 0 back to the descriptor's own address. Bit 31 is cleared and every other bit is kept, except bit 0.
- R5: A descriptor that lacks first-segment or last-segment sends no bytes. It is written back with bit 31 cleared and bit 0 set to flag the error.
- R6: A descriptor whose count field is zero sends no bytes. It is written back with bit 31 cleared and bit 0 cleared. Word 1 bits above bit 12 do not affect the count.
- R7: After write-back, the next fetch comes from the address in word 3 when word 0 bit 20 (chain) is set. When bit 20 is clear, the next fetch comes from `listBase`.
- R8: When a fetched word 0 has bit 31 clear, the engine sets `status[1]` and issues no further memory requests. After a `pollDemand` pulse it fetches the same descriptor address again.
- R9: When word 0 bit 30 is set, `status[0]` is set once that descriptor's write-back completes. This applies whether the frame was sent or dropped. Without bit 30, `status[0]` is not touched.
- R10: Both status bits reset to 0, stay set until cleared, and are cleared by a 1 on the matching `statusClr` bit. If a set and a clear arrive in the same cycle, the set wins.
- R11: `irq` equals the OR of `status & irqEn`.
- R12: With `startEn` low, a suspended engine goes idle and ignores `pollDemand`. Raising `startEn` again restarts fetching at `listBase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startEn | input | 1 | Transmission enable |
| listBase | input | AW | Address of the first descriptor |
| pollDemand | input | 1 | One-cycle pulse that resumes a suspended engine |
| statusClr | input | 2 | Write-1-to-clear strobes for the status bits |
| irqEn | input | 2 | Interrupt enable per status bit |
| status | output | 2 | Bit 0 frame done, bit 1 buffer unavailable |
| irq | output | 1 | Interrupt request |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | AW | Byte address, word aligned |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Request completed |
| txData | output | 8 | Stream byte |
| txValid | output | 1 | Stream byte valid |
| txLast | output | 1 | Final byte of a frame |
| txReady | input | 1 | Stream sink ready |

## Verification
The assertions check several properties on every cycle:
- memory requests hold steady until acknowledged;
- stream bytes hold under back-pressure;
- `txLast` never appears without `txValid`;
- every write-back carries a cleared ownership bit;
- the byte counter never steps below zero;
- the status bits stay sticky;
- a suspended engine stays off the memory port.

Other behaviour can only be shown by the directed scenarios:
- which addresses are fetched and in what order;
- the little-endian byte order and the exact byte count;
- the error and zero-count write-back values;
- following the chain pointer versus wrapping to `listBase`;
- resuming after poll demand;
- the interrupt masking.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  // word 0 bit positions
  localparam int OWN_BIT   = 31;
  localparam int IOC_BIT   = 30;
  localparam int LAST_BIT  = 29;
  localparam int FIRST_BIT = 28;
  localparam int CHAIN_BIT = 20;
  localparam int ERR_BIT   = 0;

  localparam int STATUS_W  = 2;

  typedef enum logic [2:0] {A_W0, A_W1, A_W2, A_W3, A_BUF} addrSel_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_RDBUF, S_EMIT, S_WB, S_SUSP
  } state_t;

  typedef struct packed {
    logic     loadBase;
    logic     takeW0;
    logic     takeCnt;
    logic     takeBuf;
    logic     takeNext;
    logic     takeWord;
    logic     byteStep;
    logic     advance;
    logic     setDone;
    logic     setUnavail;
    addrSel_t addrSel;
  } ctrlStrobe_t;

  typedef struct packed {
    logic rdOwned;
    logic singleBuf;
    logic zeroCnt;
    logic ioc;
    logic lastByte;
    logic wordEnd;
  } dpFlags_t;
endpackage

// File: rtl/txdma_datapath.sv
module txdma_datapath
  import txdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [AW-1:0]       listBase,
  input  ctrlStrobe_t         strobe,
  input  logic [31:0]         memRdata,
  input  logic [STATUS_W-1:0] statusClr,
  input  logic [STATUS_W-1:0] irqEn,
  output dpFlags_t            flags,
  output logic [AW-1:0]       memAddr,
  output logic [31:0]         memWdata,
  output logic [7:0]          txData,
  output logic [STATUS_W-1:0] status,
  output logic                irq
);
  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam logic [AW-1:0] OFF1 = AW'(LANES);
  localparam logic [AW-1:0] OFF2 = AW'(LANES * 2);
  localparam logic [AW-1:0] OFF3 = AW'(LANES * 3);

  logic [AW-1:0]       descAddr, nextAddr, bufPtr;
  logic [31:0]         w0Reg, wordReg;
  logic [CNT_W-1:0]    cntRemain;
  logic [LANE_W-1:0]   byteIdx;
  logic [STATUS_W-1:0] statusReg, setVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descAddr  <= '0;
      nextAddr  <= '0;
      bufPtr    <= '0;
      w0Reg     <= '0;
      wordReg   <= '0;
      cntRemain <= '0;
      byteIdx   <= '0;
    end else begin
      if (strobe.loadBase)     descAddr <= listBase;
      else if (strobe.advance) descAddr <= w0Reg[CHAIN_BIT] ? nextAddr : listBase;

      if (strobe.takeW0) w0Reg <= memRdata;

      if (strobe.takeCnt)       cntRemain <= memRdata[CNT_W-1:0];
      else if (strobe.byteStep) cntRemain <= cntRemain - 1'b1;

      if (strobe.takeBuf)
        bufPtr <= {memRdata[AW-1:LANE_W], {LANE_W{1'b0}}};
      else if (strobe.byteStep && byteIdx == LANE_W'(LANES - 1))
        bufPtr <= bufPtr + OFF1;

      if (strobe.takeBuf)       byteIdx <= '0;
      else if (strobe.byteStep) byteIdx <= byteIdx + 1'b1;

      if (strobe.takeNext) nextAddr <= memRdata[AW-1:0];
      if (strobe.takeWord) wordReg  <= memRdata;
    end
  end

  // sticky status, set has priority over clear
  assign setVec = {strobe.setUnavail, strobe.setDone};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= (statusReg & ~statusClr) | setVec;
  end

  assign status = statusReg;
  assign irq    = |(statusReg & irqEn);

  always_comb begin
    unique case (strobe.addrSel)
      A_W1:    memAddr = descAddr + OFF1;
      A_W2:    memAddr = descAddr + OFF2;
      A_W3:    memAddr = descAddr + OFF3;
      A_BUF:   memAddr = bufPtr;
      default: memAddr = descAddr;
    endcase
  end

  always_comb begin
    memWdata          = w0Reg;
    memWdata[OWN_BIT] = 1'b0;
    memWdata[ERR_BIT] = ~flags.singleBuf;
  end

  assign txData = wordReg[{byteIdx, 3'b000} +: 8];

  assign flags.rdOwned   = memRdata[OWN_BIT];
  assign flags.singleBuf = w0Reg[FIRST_BIT] & w0Reg[LAST_BIT];
  assign flags.zeroCnt   = (cntRemain == '0);
  assign flags.ioc       = w0Reg[IOC_BIT];
  assign flags.lastByte  = (cntRemain == CNT_W'(1));
  assign flags.wordEnd   = (byteIdx == LANE_W'(LANES - 1));

  // R10
  statusSticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusReg & $past(statusReg & ~statusClr)) == $past(statusReg & ~statusClr)));

  // R2
  cntUnderflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.byteStep |-> (cntRemain != '0));
endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startEn,
  input  logic        pollDemand,
  input  logic        memAck,
  input  logic        txReady,
  input  dpFlags_t    flags,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        txValid,
  output logic        txLast
);
  state_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt            = state;
    strobe         = '0;
    strobe.addrSel = A_W0;
    memReq         = 1'b0;
    memWe          = 1'b0;
    txValid        = 1'b0;
    unique case (state)
      S_IDLE: if (startEn) begin
        strobe.loadBase = 1'b1;
        nxt             = S_RD0;
      end
      S_RD0: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.takeW0 = 1'b1;
          if (flags.rdOwned) nxt = S_RD1;
          else begin
            strobe.setUnavail = 1'b1;
            nxt               = S_SUSP;
          end
        end
      end
      S_RD1: begin
        memReq         = 1'b1;
        strobe.addrSel = A_W1;
        if (memAck) begin
          strobe.takeCnt = 1'b1;
          nxt            = S_RD2;
        end
      end
      S_RD2: begin
        memReq         = 1'b1;
        strobe.addrSel = A_W2;
        if (memAck) begin
          strobe.takeBuf = 1'b1;
          nxt            = S_RD3;
        end
      end
      S_RD3: begin
        memReq         = 1'b1;
        strobe.addrSel = A_W3;
        if (memAck) begin
          strobe.takeNext = 1'b1;
          nxt = (!flags.singleBuf || flags.zeroCnt) ? S_WB : S_RDBUF;
        end
      end
      S_RDBUF: begin
        memReq         = 1'b1;
        strobe.addrSel = A_BUF;
        if (memAck) begin
          strobe.takeWord = 1'b1;
          nxt             = S_EMIT;
        end
      end
      S_EMIT: begin
        txValid = 1'b1;
        if (txReady) begin
          strobe.byteStep = 1'b1;
          if (flags.lastByte)     nxt = S_WB;
          else if (flags.wordEnd) nxt = S_RDBUF;
        end
      end
      S_WB: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          strobe.advance = 1'b1;
          strobe.setDone = flags.ioc;
          nxt            = startEn ? S_RD0 : S_IDLE;
        end
      end
      S_SUSP: begin
        if (!startEn)        nxt = S_IDLE;
        else if (pollDemand) nxt = S_RD0;
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign txLast = txValid & flags.lastByte;

  // R8
  suspendQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SUSP && !pollDemand) |=> !memReq);

  // R3
  holdValid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid);
endmodule

// File: rtl/txdma_top.sv
module txdma_top
  import txdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startEn,
  input  logic [AW-1:0] listBase,
  input  logic          pollDemand,
  input  logic [1:0]    statusClr,
  input  logic [1:0]    irqEn,
  output logic [1:0]    status,
  output logic          irq,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  input  logic          memAck,
  output logic [7:0]    txData,
  output logic          txValid,
  output logic          txLast,
  input  logic          txReady
);
  ctrlStrobe_t strobe;
  dpFlags_t    flags;

  txdma_ctrl u_ctrl (
    .clk, .rstN, .startEn, .pollDemand, .memAck, .txReady,
    .flags, .strobe, .memReq, .memWe, .txValid, .txLast
  );

  txdma_datapath #(.AW(AW), .CNT_W(CNT_W)) u_dp (
    .clk, .rstN, .listBase, .strobe, .memRdata, .statusClr, .irqEn,
    .flags, .memAddr, .memWdata, .txData, .status, .irq
  );

  // R1
  memHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R4
  wbOwn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> !memWdata[OWN_BIT]);

  // R3
  txHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> ($stable(txData) && $stable(txLast)));

  // R2
  lastValid_chk: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);
endmodule

// File: tb/tb_txdma_top.sv
module tb_txdma_top;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] IOC = 32'h4000_0000;
  localparam logic [31:0] LS  = 32'h2000_0000;
  localparam logic [31:0] FS  = 32'h1000_0000;
  localparam logic [31:0] CH  = 32'h0010_0000;

  logic        clk = 0;
  logic        rstN = 0;
  logic        startEn = 0;
  logic [31:0] listBase = 0;
  logic        pollDemand = 0;
  logic [1:0]  statusClr = 0;
  logic [1:0]  irqEn = 0;
  logic [1:0]  status;
  logic        irq, memReq, memWe, memAck, txValid, txLast;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [7:0]  txData;
  logic        txReady = 1;

  int checks = 0, fails = 0;

  logic [31:0] mem [0:1023];
  logic [31:0] rdLog [0:255];
  logic [31:0] wrAddr [0:63];
  logic [31:0] wrData [0:63];
  int rdCnt = 0, wrCnt = 0;
  logic        pokeReq = 0;
  logic [31:0] pokeAddr = 0, pokeData = 0;

  logic [7:0] byteBuf [0:63];
  logic       lastBuf [0:63];
  int  byteCnt = 0, holdErr = 0, cyc = 0;
  bit  stallOn = 0;
  logic prevValid = 0, prevReady = 0, prevLast = 0;
  logic [7:0] prevData = 0;

  txdma_top dut (
    .clk, .rstN, .startEn, .listBase, .pollDemand, .statusClr, .irqEn,
    .status, .irq, .memReq, .memWe, .memAddr, .memWdata, .memRdata, .memAck,
    .txData, .txValid, .txLast, .txReady
  );

  always #5 clk = ~clk;

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 0;
      memRdata <= 0;
      for (int i = 0; i < 1024; i++) mem[i] <= 0;
    end else begin
      memAck <= 0;
      if (pokeReq) mem[pokeAddr[11:2]] <= pokeData;
      if (memReq && !memAck) begin
        memAck <= 1;
        if (memWe) begin
          mem[memAddr[11:2]] <= memWdata;
          if (wrCnt < 64) begin
            wrAddr[wrCnt] = memAddr;
            wrData[wrCnt] = memWdata;
          end
          wrCnt++;
        end else begin
          memRdata <= mem[memAddr[11:2]];
          if (rdCnt < 256) rdLog[rdCnt] = memAddr;
          rdCnt++;
        end
      end
    end
  end

  // stream sink, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (prevValid && !prevReady)
      if (!txValid || txData != prevData || txLast != prevLast) holdErr++;
    txReady = stallOn ? (cyc % 3 != 0) : 1'b1;
    if (txValid && txReady) begin
      if (byteCnt < 64) begin
        byteBuf[byteCnt] = txData;
        lastBuf[byteCnt] = txLast;
      end
      byteCnt++;
    end
    prevValid = txValid; prevReady = txReady;
    prevData  = txData;  prevLast  = txLast;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finishRun();
  end

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    pokeAddr = a; pokeData = d; pokeReq = 1;
    @(negedge clk);
    pokeReq = 0;
  endtask

  task automatic pulsePoll();
    @(negedge clk); pollDemand = 1;
    @(negedge clk); pollDemand = 0;
  endtask

  task automatic pulseClr(input logic [1:0] c);
    @(negedge clk); statusClr = c;
    @(negedge clk); statusClr = 0;
  endtask

  task automatic waitUnavail(input string req);
    int n = 0;
    @(negedge clk);
    while (!status[1] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(status[1], req, status, 2);
  endtask

  function automatic logic [7:0] expByte(input logic [31:0] buf0, input int i);
    logic [31:0] w = mem[buf0[11:2] + 10'(i / 4)];
    return w[8*(i%4) +: 8];
  endfunction

  task automatic checkBytes(input string req, input int from, input int n, input logic [31:0] buf0);
    bit ok = 1;
    for (int i = 0; i < n; i++) begin
      if (byteBuf[from+i] !== expByte(buf0, i)) ok = 0;
      if (lastBuf[from+i] !== (i == n - 1)) ok = 0;
    end
    check(ok, req, byteBuf[from], expByte(buf0, 0));
  endtask

  task automatic t_reset();
    check(status == 2'b00, "R10 reset status", status, 0);
    check(irq == 0, "R11 reset irq", irq, 0);
    check(!txValid && !memReq, "reset idle outputs", {txValid, memReq}, 0);
  endtask

  task automatic t_first();
    int rm, wm, bm;
    logic [31:0] w0 = OWN | IOC | LS | FS | CH | 32'h40;
    poke(32'h100, w0);
    poke(32'h104, 32'hABC0_0006);
    poke(32'h108, 32'h200);
    poke(32'h10C, 32'h140);
    poke(32'h200, 32'h4433_2211);
    poke(32'h204, 32'h8877_6655);
    poke(32'h140, CH);
    poke(32'h14C, 32'h100);
    rm = rdCnt; wm = wrCnt; bm = byteCnt;
    irqEn = 2'b11; listBase = 32'h100;
    @(negedge clk); startEn = 1;
    waitUnavail("R8 first suspend");
    check(rdLog[rm] == 32'h100 && rdLog[rm+1] == 32'h104 && rdLog[rm+2] == 32'h108
          && rdLog[rm+3] == 32'h10C, "R1 descriptor fetch order", rdLog[rm+3], 32'h10C);
    check(byteCnt - bm == 6, "R2 byte count masked", byteCnt - bm, 6);
    checkBytes("R2 little-endian bytes and last", bm, 6, 32'h200);
    check(wrCnt - wm == 1 && wrAddr[wm] == 32'h100, "R4 writeback address", wrAddr[wm], 32'h100);
    check(wrData[wm] == (w0 & ~OWN), "R4 writeback value", wrData[wm], w0 & ~OWN);
    check(rdLog[rm+6] == 32'h140, "R7 chain follows word3", rdLog[rm+6], 32'h140);
    check(status == 2'b11, "R9 done status", status, 3);
    check(irq == 1, "R11 irq enabled", irq, 1);
    rm = rdCnt;
    repeat (20) @(negedge clk);
    check(rdCnt == rm, "R8 no fetch while suspended", rdCnt - rm, 0);
  endtask

  task automatic t_clear();
    pulseClr(2'b01);
    check(status == 2'b10, "R10 clear one bit", status, 2);
    irqEn = 2'b01; @(negedge clk);
    check(irq == 0, "R11 irq masked", irq, 0);
    irqEn = 2'b10; @(negedge clk);
    check(irq == 1, "R11 irq unmasked", irq, 1);
  endtask

  task automatic t_poll();
    int rm, wm, bm;
    logic [31:0] w0 = OWN | LS | FS | CH;
    poke(32'h140, w0);
    poke(32'h144, 32'd9);
    poke(32'h148, 32'h302);
    poke(32'h14C, 32'h100);
    poke(32'h300, 32'hA3A2_A1A0);
    poke(32'h304, 32'hA7A6_A5A4);
    poke(32'h308, 32'hABAA_A9A8);
    pulseClr(2'b10);
    rm = rdCnt; wm = wrCnt; bm = byteCnt; holdErr = 0;
    stallOn = 1;
    pulsePoll();
    waitUnavail("R8 second suspend");
    stallOn = 0;
    check(rdLog[rm] == 32'h140, "R8 refetch same descriptor", rdLog[rm], 32'h140);
    check(byteCnt - bm == 9, "R2 nine bytes", byteCnt - bm, 9);
    checkBytes("R2 unaligned buffer bytes", bm, 9, 32'h300);
    check(holdErr == 0, "R3 hold under backpressure", holdErr, 0);
    check(status[0] == 0, "R9 no done without flag", status, 2);
    check(wrData[wm] == (w0 & ~OWN), "R4 writeback keeps flags", wrData[wm], w0 & ~OWN);
    check(rdCnt - rm == 8 && rdLog[rdCnt-1] == 32'h100, "R7 wrap via word3",
          rdLog[rdCnt-1], 32'h100);
  endtask

  task automatic t_drop();
    int rm, wm, bm;
    logic [31:0] wa = OWN | FS | CH | IOC;
    logic [31:0] wb = OWN | FS | LS;
    poke(32'h100, wa);
    poke(32'h104, 32'd4);
    poke(32'h108, 32'h200);
    poke(32'h10C, 32'h180);
    poke(32'h180, wb);
    poke(32'h184, 32'h2000);
    poke(32'h188, 32'h200);
    poke(32'h18C, 32'h1C0);
    pulseClr(2'b11);
    rm = rdCnt; wm = wrCnt; bm = byteCnt;
    pulsePoll();
    waitUnavail("R8 third suspend");
    check(byteCnt == bm, "R5 R6 nothing streamed", byteCnt - bm, 0);
    check(wrAddr[wm] == 32'h100 && wrData[wm] == ((wa & ~OWN) | 32'h1),
          "R5 error writeback", wrData[wm], (wa & ~OWN) | 32'h1);
    check(wrAddr[wm+1] == 32'h180 && wrData[wm+1] == (wb & ~OWN),
          "R6 zero count writeback", wrData[wm+1], wb & ~OWN);
    check(rdLog[rm+4] == 32'h180, "R7 chained to word3", rdLog[rm+4], 32'h180);
    check(rdCnt - rm == 9 && rdLog[rm+8] == 32'h100, "R7 unchained returns to base",
          rdLog[rm+8], 32'h100);
    check(status[0] == 1, "R9 done on dropped descriptor", status, 3);
  endtask

  task automatic t_stop();
    int rm, bm;
    @(negedge clk); startEn = 0;
    pulsePoll();
    rm = rdCnt;
    repeat (20) @(negedge clk);
    check(rdCnt == rm, "R12 idle ignores poll", rdCnt - rm, 0);
    poke(32'h140, OWN | FS | LS | CH);
    poke(32'h144, 32'd1);
    poke(32'h148, 32'h200);
    poke(32'h14C, 32'h100);
    pulseClr(2'b11);
    rm = rdCnt; bm = byteCnt;
    listBase = 32'h140;
    @(negedge clk); startEn = 1;
    waitUnavail("R8 after restart");
    check(rdLog[rm] == 32'h140, "R12 R1 restart at base", rdLog[rm], 32'h140);
    check(byteCnt - bm == 1 && byteBuf[bm] == 8'h11 && lastBuf[bm] == 1,
          "R2 single byte frame", byteBuf[bm], 8'h11);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_first();
    t_clear();
    t_poll();
    t_drop();
    t_stop();
    finishRun();
  end
endmodule